// File: doc/BRIEF.md
# Save/Restore Sequencer Control and Status Register File

This block is the register file that sits beside a save/restore sequencer with a parameterised number of groups (16 by default). It holds one control word per group (enable, owner domain, and three sticky locks), a global control word with a software reset and a hardware-request disable, a timeout value, and an interrupt status word. The sequencer reads the enables, the hardware-request disable and the timeout value from dedicated output ports. It reports its own events as single-cycle pulses, which set the status flags.

Software reaches the registers over a simple single-cycle request bus. Each request carries a requester-domain tag. Writes take effect at the clock edge where the request is sampled. Read data appears on `rsp_rdata` one cycle after the read request. A group's locks decide whether a request is allowed. A request that is refused raises no error: a refused read returns zero and a refused write changes nothing. The descriptor storage is outside this block, so software reset has no effect on it.

Top module: `sr_csr_file`

## Requirements
- R1: After hardware reset every register is zero, so every output is zero and every read returns zero.
- R2: The group control word for group g is at address 0x10+g. It has these fields: bit 0 enable, bit 1 domain lock, bit 2 write lock, bit 3 read lock, bits [9:8] owner domain. An accepted write sets the enable to data bit 0. The owner field takes data bits [9:8] only while the domain lock is clear. `grp_en_o[g]` follows the enable.
- R3: Lock bits are sticky. A written 1 sets a lock. A written 0 does not clear it, and neither does software reset. Only hardware reset clears a lock.
- R4: While a group's write lock is set, every write to that group's control word is ignored.
- R5: While a group's read lock is set, reads of that group's control word return zero. Writes are still accepted.
- R6: While a group's domain lock is set, a request whose domain differs from the owner domain is refused: a read returns zero and a write is ignored. A request from the owner domain is still subject to the other locks.
- R7: The status word is at address 0x02, with these flags: bit 0 address error, bit 1 bus error, bit 2 software request done, bit 3 timeout, bit 4 group conflict. A pulse on the matching event input sets its flag at that clock edge.
- R8: Writing 1 to status bit 0, 1, 3 or 4 clears that flag. Writes never clear bit 2.
- R9: If an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R10: Status bits [25:16] hold the error index. The index is loaded from `ev_err_idx` whenever an address-error or bus-error pulse arrives, and is held otherwise.
- R11: The global control word is at address 0x00. Its bit 1 is the hardware-request disable, driven on `hw_req_dis_o`. The timeout value is at address 0x01 and is driven on `timeout_o`.
- R12: Writing 1 to bit 0 of the global control word is a software reset. It clears all group enables, the hardware-request disable, the timeout, the status flags and the error index, and it ignores the other bits of that write. Lock bits and owner domains are kept, and bit 0 always reads 0. A software reset overrides event pulses arriving in the same cycle.
- R13: A read of an address with no register returns zero. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 32 | Write data |
| req_domain | input | 2 | Domain tag of the requester |
| rsp_rdata | output | 32 | Read result, one cycle after a read; zero otherwise |
| ev_addr_err | input | 1 | Sequencer pulse: address error |
| ev_bus_err | input | 1 | Sequencer pulse: bus error |
| ev_req_done | input | 1 | Sequencer pulse: software request done |
| ev_timeout | input | 1 | Sequencer pulse: group timeout |
| ev_conflict | input | 1 | Sequencer pulse: group conflict |
| ev_err_idx | input | 10 | Descriptor index accompanying an error pulse |
| grp_en_o | output | 16 | Per-group enable |
| hw_req_dis_o | output | 1 | Hardware request disable |
| timeout_o | output | 32 | Timeout value |

## Verification
The hardest situations to reach from the ports combine locks. Examples are an owner-domain write to a group that also has its write lock set, or a software reset arriving after some groups are locked and owned, followed by checks that locks and owners survive while enables clear. Getting there needs lock-setting writes, which seal a group until the next hardware reset. The stimulus therefore sets lock bits only occasionally in the random phase and applies a hardware reset every few hundred operations. A directed sequence builds the combined states on purpose. A second hard case is an event pulse coinciding with a write-1 clear of the same flag. The bench drives that coincidence directly and also lets the random phase pair clears with pulses.

// File: rtl/sr_csr_pkg.sv
package sr_csr_pkg;
  localparam int DATA_W = 32;
  localparam int DOM_W  = 2;
  localparam int NFLAG  = 5;

  localparam int FL_ADDR = 0;
  localparam int FL_BUS  = 1;
  localparam int FL_DONE = 2;
  localparam int FL_TMO  = 3;
  localparam int FL_CONF = 4;

  // flags that a software write of 1 may clear (all but request-done)
  localparam logic [NFLAG-1:0] W1C_MASK = 5'b11011;

  localparam int OWN_LSB = 8;
  localparam int IDX_LSB = 16;

  // access passes the domain check when unlocked or owner matches
  function automatic logic dom_pass(input logic dlock,
                                    input logic [DOM_W-1:0] owner,
                                    input logic [DOM_W-1:0] dom);
    return !dlock || (owner == dom);
  endfunction

  // next flag value: reset beats everything, then set beats clear
  function automatic logic [NFLAG-1:0] flag_next(input logic [NFLAG-1:0] cur,
                                                 input logic [NFLAG-1:0] set,
                                                 input logic [NFLAG-1:0] clr,
                                                 input logic             srst);
    if (srst) return '0;
    return (cur & ~(clr & W1C_MASK)) | set;
  endfunction

  function automatic logic [DATA_W-1:0] grp_pack(input logic en, input logic dl,
                                                 input logic wl, input logic rl,
                                                 input logic [DOM_W-1:0] own);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = en;
    w[1] = dl;
    w[2] = wl;
    w[3] = rl;
    w[OWN_LSB +: DOM_W] = own;
    return w;
  endfunction
endpackage

// File: rtl/sr_csr_grp.sv
module sr_csr_grp
  import sr_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             sel,
  input  logic             wr,
  input  logic             wr_en_bit,
  input  logic [2:0]       wr_lock_bits,
  input  logic [DOM_W-1:0] wr_owner,
  input  logic [DOM_W-1:0] dom,
  output logic             en,
  output logic             dlock,
  output logic             wlock,
  output logic             rlock,
  output logic [DOM_W-1:0] owner,
  output logic             wr_take,
  output logic             wr_block,
  output logic             rd_ok
);
  logic pass;

  assign pass     = dom_pass(dlock, owner, dom);
  assign wr_take  = sel && wr && pass && !wlock;
  assign wr_block = sel && wr && !wr_take;
  assign rd_ok    = pass && !rlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      dlock <= 1'b0;
      wlock <= 1'b0;
      rlock <= 1'b0;
      owner <= '0;
    end else begin
      if (sw_rst) begin
        en <= 1'b0;
      end else if (wr_take) begin
        en    <= wr_en_bit;
        dlock <= dlock | wr_lock_bits[0];
        wlock <= wlock | wr_lock_bits[1];
        rlock <= rlock | wr_lock_bits[2];
        if (!dlock) owner <= wr_owner;
      end
    end
  end
endmodule

// File: rtl/sr_csr_status.sv
module sr_csr_status
  import sr_csr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic [NFLAG-1:0] ev,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             clr_en,
  input  logic [NFLAG-1:0] clr_bits,
  output logic [NFLAG-1:0] flags,
  output logic [IDX_W-1:0] err_idx
);
  logic [NFLAG-1:0] clr_vec;
  logic             idx_load;

  assign clr_vec  = clr_en ? clr_bits : '0;
  assign idx_load = ev[FL_ADDR] || ev[FL_BUS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      err_idx <= '0;
    end else begin
      flags <= flag_next(flags, ev, clr_vec, sw_rst);
      if (sw_rst)        err_idx <= '0;
      else if (idx_load) err_idx <= ev_idx;
    end
  end
endmodule

// File: rtl/sr_csr_file.sv
module sr_csr_file
  import sr_csr_pkg::*;
#(
  parameter int NG     = 16,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 10,
  parameter int TMO_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DOM_W-1:0]  req_domain,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ev_addr_err,
  input  logic              ev_bus_err,
  input  logic              ev_req_done,
  input  logic              ev_timeout,
  input  logic              ev_conflict,
  input  logic [IDX_W-1:0]  ev_err_idx,
  output logic [NG-1:0]     grp_en_o,
  output logic              hw_req_dis_o,
  output logic [TMO_W-1:0]  timeout_o
);
  localparam int GLOB_A   = 0;
  localparam int TMO_A    = 1;
  localparam int STAT_A   = 2;
  localparam int GRP_BASE = 16;

  logic sel_glob, sel_tmo, sel_stat;
  logic sw_rst;
  logic hw_dis;
  logic [TMO_W-1:0] tmo;

  logic [NG-1:0]          grp_sel, grp_dl, grp_wl, grp_rl;
  logic [NG-1:0]          wr_take, wr_blocked, grp_rd_ok;
  logic [NG-1:0][DOM_W-1:0] grp_own;
  logic [3*NG-1:0]        lock_vec;
  logic                   rd_blocked;

  logic [NFLAG-1:0] ev_vec, stat_flags;
  logic [IDX_W-1:0] err_idx;
  logic             stat_clr;
  logic [DATA_W-1:0] rd_val;

  assign sel_glob = req_valid && (req_addr == ADDR_W'(GLOB_A));
  assign sel_tmo  = req_valid && (req_addr == ADDR_W'(TMO_A));
  assign sel_stat = req_valid && (req_addr == ADDR_W'(STAT_A));
  assign sw_rst   = sel_glob && req_write && req_wdata[0];
  assign stat_clr = sel_stat && req_write;

  assign ev_vec = {ev_conflict, ev_timeout, ev_req_done, ev_bus_err, ev_addr_err};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_dis <= 1'b0;
      tmo    <= '0;
    end else if (sw_rst) begin
      hw_dis <= 1'b0;
      tmo    <= '0;
    end else begin
      if (sel_glob && req_write) hw_dis <= req_wdata[1];
      if (sel_tmo && req_write)  tmo    <= req_wdata[TMO_W-1:0];
    end
  end

  for (genvar g = 0; g < NG; g++) begin : gen_grp
    assign grp_sel[g] = req_valid && (req_addr == ADDR_W'(GRP_BASE + g));
    sr_csr_grp u_grp (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_rst       (sw_rst),
      .sel          (grp_sel[g]),
      .wr           (req_write),
      .wr_en_bit    (req_wdata[0]),
      .wr_lock_bits (req_wdata[3:1]),
      .wr_owner     (req_wdata[OWN_LSB +: DOM_W]),
      .dom          (req_domain),
      .en           (grp_en_o[g]),
      .dlock        (grp_dl[g]),
      .wlock        (grp_wl[g]),
      .rlock        (grp_rl[g]),
      .owner        (grp_own[g]),
      .wr_take      (wr_take[g]),
      .wr_block     (wr_blocked[g]),
      .rd_ok        (grp_rd_ok[g])
    );
    assign lock_vec[3*g +: 3] = {grp_rl[g], grp_wl[g], grp_dl[g]};
  end

  sr_csr_status #(.IDX_W(IDX_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .ev       (ev_vec),
    .ev_idx   (ev_err_idx),
    .clr_en   (stat_clr),
    .clr_bits (req_wdata[NFLAG-1:0]),
    .flags    (stat_flags),
    .err_idx  (err_idx)
  );

  always_comb begin
    rd_val     = '0;
    rd_blocked = 1'b0;
    if (sel_glob) begin
      rd_val[1] = hw_dis;
    end else if (sel_tmo) begin
      rd_val = DATA_W'(tmo);
    end else if (sel_stat) begin
      rd_val[NFLAG-1:0]        = stat_flags;
      rd_val[IDX_LSB +: IDX_W] = err_idx;
    end
    for (int g = 0; g < NG; g++) begin
      if (grp_sel[g]) begin
        rd_val     = grp_rd_ok[g] ?
                     grp_pack(grp_en_o[g], grp_dl[g], grp_wl[g], grp_rl[g], grp_own[g]) : '0;
        rd_blocked = !req_write && !grp_rd_ok[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rsp_rdata <= '0;
    else if (req_valid && !req_write) rsp_rdata <= rd_val;
    else                             rsp_rdata <= '0;
  end

  assign hw_req_dis_o = hw_dis;
  assign timeout_o    = tmo;
endmodule

// File: rtl/sr_csr_file_chk.sv
module sr_csr_file_chk
  import sr_csr_pkg::*;
#(
  parameter int NG    = 16,
  parameter int TMO_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_rst,
  input logic [3*NG-1:0]   lock_vec,
  input logic [NG-1:0]     wr_blocked,
  input logic              rd_blocked,
  input logic [NG-1:0]     grp_en_o,
  input logic              hw_req_dis_o,
  input logic [TMO_W-1:0]  timeout_o,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NFLAG-1:0]  ev_vec,
  input logic [NFLAG-1:0]  stat_flags
);
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

  assert_wr_lock_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_blocked) |=> ($stable(grp_en_o) && $stable(lock_vec)));

  assert_rd_block_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blocked |=> (rsp_rdata == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && (ev_vec != '0)) |=> ((stat_flags & $past(ev_vec)) == $past(ev_vec)));

  assert_done_not_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flags[FL_DONE] && !sw_rst) |=> stat_flags[FL_DONE]);

  assert_swrst_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (grp_en_o == '0 && !hw_req_dis_o && timeout_o == '0 && stat_flags == '0));
endmodule

bind sr_csr_file sr_csr_file_chk #(.NG(NG), .TMO_W(TMO_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_rst       (sw_rst),
  .lock_vec     (lock_vec),
  .wr_blocked   (wr_blocked),
  .rd_blocked   (rd_blocked),
  .grp_en_o     (grp_en_o),
  .hw_req_dis_o (hw_req_dis_o),
  .timeout_o    (timeout_o),
  .rsp_rdata    (rsp_rdata),
  .ev_vec       (ev_vec),
  .stat_flags   (stat_flags)
);

// File: tb/sr_csr_file_tb_top.sv
module sr_csr_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_domain = '0;
  logic [31:0] rsp_rdata;
  logic [4:0]  ev = '0;
  logic [9:0]  ev_idx = '0;
  logic [15:0] grp_en_o;
  logic        hw_req_dis_o;
  logic [31:0] timeout_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the registers
  bit         m_en[16], m_dl[16], m_wl[16], m_rl[16];
  logic [1:0] m_own[16];
  bit         m_hw;
  logic [31:0] m_tmo;
  logic [4:0]  m_fl;
  logic [9:0]  m_idx;

  always #10 clk = ~clk;

  sr_csr_file dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_domain(req_domain),
    .rsp_rdata(rsp_rdata), .ev_addr_err(ev[0]), .ev_bus_err(ev[1]),
    .ev_req_done(ev[2]), .ev_timeout(ev[3]), .ev_conflict(ev[4]),
    .ev_err_idx(ev_idx), .grp_en_o(grp_en_o), .hw_req_dis_o(hw_req_dis_o),
    .timeout_o(timeout_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int g = 0; g < 16; g++) begin
      m_en[g] = 0; m_dl[g] = 0; m_wl[g] = 0; m_rl[g] = 0; m_own[g] = '0;
    end
    m_hw = 0; m_tmo = '0; m_fl = '0; m_idx = '0;
  endtask

  function automatic bit pass_dom(int g, logic [1:0] dom);
    return !m_dl[g] || (m_own[g] == dom);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a, logic [1:0] dom);
    logic [31:0] r;
    int g;
    r = '0;
    if (a == 8'h00) r[1] = m_hw;
    else if (a == 8'h01) r = m_tmo;
    else if (a == 8'h02) r = {6'd0, m_idx, 11'd0, m_fl};
    else if (a >= 8'h10 && a < 8'h20) begin
      g = int'(a) - 16;
      if (pass_dom(g, dom) && !m_rl[g])
        r = {22'd0, m_own[g], 4'd0, m_rl[g], m_wl[g], m_dl[g], m_en[g]};
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_en();
    logic [15:0] v;
    for (int g = 0; g < 16; g++) v[g] = m_en[g];
    return v;
  endfunction

  // apply one sampled cycle to the model
  task automatic model_step(bit v, bit w, logic [7:0] a, logic [31:0] d,
                            logic [1:0] dom, logic [4:0] e, logic [9:0] ix);
    bit srst;
    logic [4:0] clr;
    int g;
    srst = v && w && a == 8'h00 && d[0];
    clr  = (v && w && a == 8'h02) ? (d[4:0] & 5'b11011) : 5'd0;
    if (srst) begin
      for (int k = 0; k < 16; k++) m_en[k] = 0;
      m_hw = 0; m_tmo = '0; m_fl = '0; m_idx = '0;
    end else begin
      m_fl = (m_fl & ~clr) | e;
      if (e[0] || e[1]) m_idx = ix;
      if (v && w) begin
        if (a == 8'h00) m_hw = d[1];
        else if (a == 8'h01) m_tmo = d;
        else if (a >= 8'h10 && a < 8'h20) begin
          g = int'(a) - 16;
          if (pass_dom(g, dom) && !m_wl[g]) begin
            m_en[g] = d[0];
            if (!m_dl[g]) m_own[g] = d[9:8];
            m_dl[g] = m_dl[g] | d[1];
            m_wl[g] = m_wl[g] | d[2];
            m_rl[g] = m_rl[g] | d[3];
          end
        end
      end
    end
  endtask

  task automatic cyc(input string tag, input bit v, input bit w, input logic [7:0] a,
                     input logic [31:0] d, input logic [1:0] dom,
                     input logic [4:0] e, input logic [9:0] ix);
    logic [31:0] er;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_domain = dom;
    ev = e; ev_idx = ix;
    er = (v && !w) ? exp_read(a, dom) : 32'd0;
    model_step(v, w, a, d, dom, e, ix);
    @(negedge clk);
    req_valid = 0; req_write = 0; ev = '0;
    check({tag, " rdata"}, rsp_rdata, er);
    check({tag, " grp_en_o"}, {16'd0, grp_en_o}, {16'd0, exp_en()});
    check({tag, " hw_req_dis_o"}, {31'd0, hw_req_dis_o}, {31'd0, m_hw});
    check({tag, " timeout_o"}, timeout_o, m_tmo);
  endtask

  task automatic wr(input string t, input logic [7:0] a, input logic [31:0] d, input logic [1:0] dom);
    cyc(t, 1, 1, a, d, dom, 5'd0, 10'd0);
  endtask

  task automatic rd(input string t, input logic [7:0] a, input logic [1:0] dom);
    cyc(t, 1, 0, a, 32'd0, dom, 5'd0, 10'd0);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd("R1 glob", 8'h00, 2'd0);
    rd("R1 tmo", 8'h01, 2'd0);
    rd("R1 stat", 8'h02, 2'd0);
    rd("R1 grp", 8'h13, 2'd1);

    // R2 layout, owner field
    wr("R2 write g3", 8'h13, 32'h0000_0201, 2'd1);
    rd("R2 read g3", 8'h13, 2'd3);
    // R6 domain lock owned by domain 2
    wr("R6 lock g3", 8'h13, 32'h0000_0203, 2'd2);
    rd("R6 foreign read", 8'h13, 2'd0);
    wr("R6 foreign write", 8'h13, 32'h0000_0000, 2'd0);
    rd("R6 owner read", 8'h13, 2'd2);
    wr("R2 owner frozen", 8'h13, 32'h0000_0103, 2'd2);
    rd("R2 owner frozen read", 8'h13, 2'd2);

    // R4 write lock
    wr("R4 lock g5", 8'h15, 32'h0000_0005, 2'd0);
    wr("R4 blocked write", 8'h15, 32'h0000_0000, 2'd0);
    rd("R4 read g5", 8'h15, 2'd0);

    // R5 read lock
    wr("R5 lock g6", 8'h16, 32'h0000_0009, 2'd0);
    rd("R5 blocked read", 8'h16, 2'd0);
    wr("R3 write zero g6", 8'h16, 32'h0000_0000, 2'd0);
    rd("R3 rlock kept", 8'h16, 2'd0);

    // R11 global and timeout
    wr("R11 hw dis", 8'h00, 32'h0000_0002, 2'd0);
    wr("R11 timeout", 8'h01, 32'hDEAD_BEEF, 2'd0);
    rd("R11 read glob", 8'h00, 2'd0);
    rd("R11 read tmo", 8'h01, 2'd0);

    // R7, R10 events
    cyc("R7 R10 addr err", 1, 0, 8'h02, 32'd0, 2'd0, 5'b00001, 10'h2A5);
    cyc("R7 other flags", 0, 0, 8'h00, 32'd0, 2'd0, 5'b11100, 10'h111);
    rd("R10 idx held", 8'h02, 2'd0);
    cyc("R10 bus err", 0, 0, 8'h00, 32'd0, 2'd0, 5'b00010, 10'h3FF);
    rd("R10 idx reload", 8'h02, 2'd0);

    // R8 W1C, done flag stays
    wr("R8 clear all", 8'h02, 32'h0000_001F, 2'd0);
    rd("R8 done remains", 8'h02, 2'd0);
    // R9 set wins
    cyc("R9 same cycle", 1, 1, 8'h02, 32'h0000_0008, 2'd0, 5'b01000, 10'd0);
    rd("R9 read", 8'h02, 2'd0);

    // R13 unmapped
    wr("R13 write", 8'h40, 32'hFFFF_FFFF, 2'd0);
    rd("R13 read", 8'h40, 2'd0);
    rd("R13 read gap", 8'h05, 2'd0);

    // R12 software reset with a coincident event
    wr("R12 set g7", 8'h17, 32'h0000_0001, 2'd0);
    cyc("R12 swrst", 1, 1, 8'h00, 32'h0000_0003, 2'd0, 5'b11111, 10'h055);
    rd("R12 stat", 8'h02, 2'd0);
    rd("R12 glob", 8'h00, 2'd0);
    rd("R12 g5 keeps wlock", 8'h15, 2'd0);
    rd("R12 g3 keeps owner", 8'h13, 2'd2);
    rd("R12 g3 foreign", 8'h13, 2'd1);

    hw_reset();
    rd("R1 after hw reset g3", 8'h13, 2'd0);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int kind;
      logic [31:0] d;
      logic [7:0] a;
      logic [4:0] e;
      if (i % 400 == 399) hw_reset();
      kind = $urandom_range(0, 9);
      d = $urandom();
      a = 8'h10 + 8'($urandom_range(0, 15));
      e = ($urandom_range(0, 3) == 0) ? 5'($urandom()) : 5'd0;
      if ($urandom_range(0, 15) != 0) d[3:1] = 3'd0;
      case (kind)
        0, 1, 2: cyc("R2 R4 R6 rnd grp write", 1, 1, a, d, 2'($urandom()), e, 10'($urandom()));
        3, 4:    cyc("R5 R6 rnd grp read", 1, 0, a, 32'd0, 2'($urandom()), e, 10'($urandom()));
        5:       cyc("R8 R9 rnd stat write", 1, 1, 8'h02, d, 2'd0, e, 10'($urandom()));
        6:       cyc("R7 R10 rnd stat read", 1, 0, 8'h02, 32'd0, 2'd0, e, 10'($urandom()));
        7:       cyc("R11 rnd tmo", 1, 1, 8'h01, d, 2'd0, e, 10'($urandom()));
        8:       cyc("R11 R12 rnd glob", 1, 1, 8'h00,
                     {d[31:1], ($urandom_range(0, 7) == 0)}, 2'd0, e, 10'($urandom()));
        default: cyc("R13 rnd read", 1, 0, 8'($urandom()), 32'd0, 2'($urandom()), e, 10'($urandom()));
      endcase
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule